// File: doc/BRIEF.md
# I2C Control Register Target

This block is an I2C target that gives a host controller read and write access to a small file of 8-bit control registers. The registers sit in a 16-bit address space. The host sends the target's 7-bit device address, then a register address as two bytes with the low byte first, and then any number of data bytes. The register pointer advances by one after every data byte, so one transfer can fill a run of registers.

Reads are split into two transfers. First the host performs a write that carries only the two address bytes, and ends it with a stop or with a repeated start. Then it opens a read transfer, and the target returns bytes starting from the stored pointer, advancing after each byte until the host answers with a NACK.

The register values leave the block on one flat bus, so downstream logic can use them directly. Register 0x0819 carries a fixed die identifier in its upper six bits. Setting bit 0 of register 0x081F returns every register to its reset value.

Top module: `ctlbus_i2c_target`

## Requirements
- R1: The target answers device address 0x5D, which gives a first byte of 0xBA for a write and 0xBB for a read (bit 0 is the direction, 1 = read). It acknowledges by holding SDA low while SCL is high in the ninth clock. For any other address it does not acknowledge, and it ignores the bus until the next start.
- R2: In a write, the first two bytes after the device address form the register pointer, low byte first. Every later byte is written at the pointer, and the pointer then increments by one.
- R3: A read transfer returns bytes MSB first, starting at the pointer left by an earlier address-only write (ended by a stop or a repeated start). The pointer increments after each byte. When the host answers a byte with a NACK, the target releases SDA.
- R4: The mapped registers are 0x0800–0x0805 and 0x0810–0x081F. A data byte written to any other address is acknowledged and discarded, and a read from any other address returns 0x00.
- R5: Reset values: 0x0802=0xD0, 0x0803=0xCC, 0x0804=0x04, 0x0805=0x10, 0x0810–0x0813=0xE0, 0x0814–0x0817=0x80, 0x0818=0x94, 0x081E=0x16, 0x0819={DIE_ID,2'b00}, and 0x00 for all others.
- R6: Bits 7:2 of 0x0819 always hold the DIE_ID parameter, and writes from the host cannot change them. Bits 1:0 are writable.
- R7: Writing a byte with bit 0 set to 0x081F raises that bit for one clock. In the next clock every register, 0x081F included, returns to its R5 value, so 0x081F reads 0x00. The I2C transfer in progress continues, and later bytes of it are still acknowledged.
- R8: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A repeated start at any bit position restarts device-address reception. The target changes SDA only while SCL is low, and it releases SDA on a stop.
- R9: `regs_flat` carries byte slot k at bits [8k+7:8k]. Slots 0–5 hold 0x0800–0x0805 and slots 6–21 hold 0x0810–0x081F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_flat | output | 176 | All register values, byte slots as in R9 |

## Verification
The hardest case to reach from the ports is a repeated start that arrives partway through a byte. The host must raise SDA while SCL is low and then drop it while SCL is high, after only a few data bits, and the target must then abandon the half-received byte. The bench reaches this case by sending four bits of a data byte, issuing a new start, and writing a different register. It then checks that only the second write landed. The soft reset is reached inside a transfer that continues with one more byte, so the reload and the acknowledge of that byte are both observed.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;

  localparam logic [15:0] LO_BASE  = 16'h0800;
  localparam int          LO_CNT   = 6;
  localparam logic [15:0] HI_BASE  = 16'h0810;
  localparam int          HI_CNT   = 16;
  localparam int          NREG     = LO_CNT + HI_CNT;
  localparam int          IDX_W    = $clog2(NREG);
  localparam int          ID_IDX   = LO_CNT + 9;
  localparam int          SRST_IDX = NREG - 1;
  localparam logic [15:0] LO_END   = LO_BASE + 16'(LO_CNT);
  localparam logic [15:0] HI_END   = HI_BASE + 16'(HI_CNT);

  typedef enum logic [1:0] {
    PH_ALO  = 2'd0,
    PH_AHI  = 2'd1,
    PH_DATA = 2'd2
  } rx_phase_t;

  function automatic logic map_hit(input logic [15:0] a);
    return ((a >= LO_BASE) && (a < LO_END)) || ((a >= HI_BASE) && (a < HI_END));
  endfunction

  function automatic logic [IDX_W-1:0] map_idx(input logic [15:0] a);
    if (a < HI_BASE) return IDX_W'(a - LO_BASE);
    else             return IDX_W'(a - HI_BASE + 16'(LO_CNT));
  endfunction

  function automatic logic [7:0] reg_default(input int idx, input logic [5:0] die);
    case (idx)
      2:                  return 8'hD0;
      3:                  return 8'hCC;
      4:                  return 8'h04;
      5:                  return 8'h10;
      6, 7, 8, 9:         return 8'hE0;
      10, 11, 12, 13:     return 8'h80;
      14:                 return 8'h94;
      ID_IDX:             return {die, 2'b00};
      20:                 return 8'h16;
      default:            return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ctlbus_line_sync.sv
module ctlbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], line_i};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl  = sh[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/ctlbus_byte_engine.sv
module ctlbus_byte_engine
  import ctlbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5D
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_evt,
  input  logic      stop_evt,
  input  logic      scl_rise,
  input  logic      scl_fall,
  input  logic      sda_lvl,
  input  logic [7:0] rd_byte,
  output logic      sda_oe,
  output logic      rx_stb,
  output logic [7:0] rx_byte,
  output rx_phase_t rx_phase,
  output logic      tx_adv
);
  typedef enum logic [2:0] {
    E_IDLE, E_DEV, E_RX, E_ACK, E_TX, E_MACK, E_SKIP
  } eng_st_t;

  eng_st_t   st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [7:0] txs;
  logic       rw;
  logic       match;
  logic       mack_ok;
  rx_phase_t  bidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      cnt      <= '0;
      sh       <= '0;
      txs      <= '0;
      rw       <= 1'b0;
      match    <= 1'b0;
      mack_ok  <= 1'b0;
      bidx     <= PH_ALO;
      sda_oe   <= 1'b0;
      rx_stb   <= 1'b0;
      rx_byte  <= '0;
      rx_phase <= PH_ALO;
      tx_adv   <= 1'b0;
    end else begin
      rx_stb <= 1'b0;
      tx_adv <= 1'b0;
      if (start_evt) begin
        st     <= E_DEV;
        cnt    <= '0;
        bidx   <= PH_ALO;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st     <= E_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          E_DEV, E_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                if (st == E_DEV) begin
                  rw    <= sda_lvl;
                  match <= (sh[6:0] == DEV_ADDR);
                end else begin
                  rx_stb   <= 1'b1;
                  rx_byte  <= {sh[6:0], sda_lvl};
                  rx_phase <= bidx;
                  if (bidx == PH_ALO) bidx <= PH_AHI;
                  else                bidx <= PH_DATA;
                end
              end
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == E_DEV && !match) begin
                st <= E_SKIP;
              end else begin
                sda_oe <= 1'b1;
                st     <= E_ACK;
              end
            end
          end
          E_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                txs    <= rd_byte;
                sda_oe <= ~rd_byte[7];
                st     <= E_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= E_RX;
              end
            end
          end
          E_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                tx_adv <= 1'b1;
                st     <= E_MACK;
              end else begin
                txs    <= {txs[6:0], 1'b0};
                sda_oe <= ~txs[6];
              end
            end
          end
          E_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_ok) begin
                cnt    <= '0;
                txs    <= rd_byte;
                sda_oe <= ~rd_byte[7];
                st     <= E_TX;
              end else begin
                st <= E_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctlbus_reg_file.sv
module ctlbus_reg_file
  import ctlbus_pkg::*;
#(
  parameter logic [5:0] DIE_ID = 6'h2D
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_stb,
  input  logic [7:0]           rx_byte,
  input  rx_phase_t            rx_phase,
  input  logic                 tx_adv,
  output logic [7:0]           rd_byte,
  output logic [NREG*8-1:0]    regs_flat
);
  logic [7:0]       regs [NREG];
  logic [15:0]      ptr;
  logic             hit;
  logic [IDX_W-1:0] widx;

  assign hit  = map_hit(ptr);
  assign widx = map_idx(ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      for (int k = 0; k < NREG; k++) regs[k] <= reg_default(k, DIE_ID);
    end else begin
      if (regs[SRST_IDX][0]) begin
        for (int k = 0; k < NREG; k++) regs[k] <= reg_default(k, DIE_ID);
      end else if (rx_stb && rx_phase == PH_DATA && hit) begin
        if (widx == IDX_W'(ID_IDX))        regs[widx] <= {DIE_ID, rx_byte[1:0]};
        else if (widx == IDX_W'(SRST_IDX)) regs[widx] <= {7'b0, rx_byte[0]};
        else                               regs[widx] <= rx_byte;
      end
      if (rx_stb) begin
        case (rx_phase)
          PH_ALO:  ptr[7:0]  <= rx_byte;
          PH_AHI:  ptr[15:8] <= rx_byte;
          default: ptr       <= ptr + 16'd1;
        endcase
      end else if (tx_adv) begin
        ptr <= ptr + 16'd1;
      end
    end
  end

  assign rd_byte = hit ? regs[widx] : 8'h00;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/ctlbus_i2c_target.sv
module ctlbus_i2c_target
  import ctlbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5D,
  parameter logic [5:0] DIE_ID      = 6'h2D,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_flat
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_evt, stop_evt;
  logic rx_stb, tx_adv;
  logic [7:0] rx_byte, rd_byte;
  rx_phase_t rx_phase;

  ctlbus_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  ctlbus_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  assign start_evt = scl_lvl & sda_fall;
  assign stop_evt  = scl_lvl & sda_rise;

  ctlbus_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst(rst),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .rd_byte(rd_byte), .sda_oe(sda_oe),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .rx_phase(rx_phase), .tx_adv(tx_adv)
  );

  ctlbus_reg_file #(.DIE_ID(DIE_ID)) u_regs (
    .clk(clk), .rst(rst),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .rx_phase(rx_phase), .tx_adv(tx_adv),
    .rd_byte(rd_byte), .regs_flat(regs_flat)
  );
endmodule

// File: rtl/ctlbus_i2c_chk.sv
module ctlbus_i2c_chk
  import ctlbus_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              stop_evt,
  input logic [NREG*8-1:0] regs_flat
);
  logic srst_bit;
  assign srst_bit = regs_flat[SRST_IDX*8];

  // R8
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  // R7
  srst_reload_chk: assert property (@(posedge clk) disable iff (rst)
    srst_bit |=> (!srst_bit && regs_flat[2*8 +: 8] == 8'hD0
                  && regs_flat[6*8 +: 8] == 8'hE0 && regs_flat[14*8 +: 8] == 8'h94));

  // R6
  die_id_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(regs_flat[ID_IDX*8+2 +: 6]));

  // R5
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs_flat[4*8 +: 8] == 8'h04 && regs_flat[20*8 +: 8] == 8'h16));
endmodule

bind ctlbus_i2c_target ctlbus_i2c_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .stop_evt(stop_evt), .regs_flat(regs_flat)
);

// File: tb/test_ctlbus_i2c_target.sv
module test_ctlbus_i2c_target;
  import ctlbus_pkg::*;

  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 6;
  localparam logic [6:0] DEV        = 7'h5D;
  localparam logic [5:0] DIE        = 6'h2D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] regs_flat;
  int nchk = 0;
  int nerr = 0;
  logic [7:0] mdl [32];

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlbus_i2c_target #(.DEV_ADDR(DEV), .DIE_ID(DIE), .SYNC_STAGES(2)) i_ctlbus_i2c_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_flat(regs_flat)
  );

  function automatic bit is_mapped(input int i);
    return (i < 6) || (i >= 16 && i < 32);
  endfunction

  function automatic logic [7:0] dflt(input int i);
    case (i)
      2: return 8'hD0;
      3: return 8'hCC;
      4: return 8'h04;
      5: return 8'h10;
      16, 17, 18, 19: return 8'hE0;
      20, 21, 22, 23: return 8'h80;
      24: return 8'h94;
      25: return {DIE, 2'b00};
      30: return 8'h16;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] get_slot(input int i);
    int s;
    s = (i < 6) ? i : i - 10;
    return regs_flat[s*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic x;
    for (int k = 7; k >= 0; k--) put_bit(b[k]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic x;
    for (int k = 7; k >= 0; k--) begin
      get_bit(x);
      d[k] = x;
    end
    put_bit(nack);
  endtask

  task automatic set_ptr(input logic [7:0] lo, input logic [7:0] hi);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack, "R1 write address acknowledged", int'(ack), 1);
    send_byte(lo, ack);
    check(ack, "R2 pointer low byte acknowledged", int'(ack), 1);
    send_byte(hi, ack);
    check(ack, "R2 pointer high byte acknowledged", int'(ack), 1);
  endtask

  task automatic read_run(input int first, input int n, input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R1 read address acknowledged", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte((i == n - 1), d);
      check(d == mdl[first + i], tag, int'(d), int'(mdl[first + i]));
    end
    check(sda_oe == 1'b0, "R3 SDA released after host NACK", int'(sda_oe), 0);
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 32; i++) mdl[i] = is_mapped(i) ? dflt(i) : 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Reset state: R5, R9
    check(sda_oe == 1'b0, "R8 SDA released after reset", int'(sda_oe), 0);
    for (int i = 0; i < 32; i++)
      if (is_mapped(i))
        check(get_slot(i) == dflt(i), "R5 R9 reset value on regs_flat", int'(get_slot(i)), int'(dflt(i)));

    // Read all defaults after address-only write and stop: R3 R4 R5
    set_ptr(8'h00, 8'h08);
    bus_stop();
    read_run(0, 32, "R3 R4 R5 default readback");
    bus_stop();

    // Burst write 0x0800..0x081E: R2 R4 R6
    set_ptr(8'h00, 8'h08);
    for (int i = 0; i < 31; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 11) & 255);
      send_byte(d, ack);
      check(ack, "R4 every data byte acknowledged", int'(ack), 1);
      if (i == 25)          mdl[i] = {DIE, d[1:0]};
      else if (is_mapped(i)) mdl[i] = d;
    end
    bus_stop();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 31; i++)
      if (is_mapped(i))
        check(get_slot(i) == mdl[i], "R2 R9 burst value on regs_flat", int'(get_slot(i)), int'(mdl[i]));

    // Readback through repeated start without stop: R3 R4 R6 R8
    set_ptr(8'h00, 8'h08);
    read_run(0, 31, "R3 R4 R6 burst readback");
    bus_stop();
    // Pointer retained across transfers: now at 0x081F, then 0x0820
    read_run(31, 1, "R3 pointer continues to 0x081F");
    bus_stop();
    read_run(6, 1, "R4 unmapped 0x0820 reads zero");
    bus_stop();

    // Foreign addresses: R1
    for (int a = 0; a < 128; a++) begin
      if (a != int'(DEV)) begin
        bus_start();
        send_byte({7'(a), 1'(a & 1)}, ack);
        check(!ack, "R1 foreign address not acknowledged", int'(ack), 0);
        bus_stop();
      end
    end
    bus_start();
    send_byte({DEV + 7'd1, 1'b0}, ack);
    send_byte(8'h02, ack);
    check(!ack, "R1 bytes after foreign address ignored", int'(ack), 0);
    send_byte(8'h08, ack);
    send_byte(8'h99, ack);
    bus_stop();
    repeat (4) @(negedge clk);
    check(get_slot(2) == mdl[2], "R1 register untouched by foreign transfer", int'(get_slot(2)), int'(mdl[2]));

    // Repeated start partway through a byte: R8 R2
    set_ptr(8'h02, 8'h08);
    for (int k = 0; k < 4; k++) put_bit(1'b1);
    set_ptr(8'h03, 8'h08);
    send_byte(8'h77, ack);
    check(ack, "R8 write after mid-byte restart acknowledged", int'(ack), 1);
    mdl[3] = 8'h77;
    bus_stop();
    repeat (4) @(negedge clk);
    check(get_slot(3) == 8'h77, "R8 R2 write after mid-byte restart", int'(get_slot(3)), 32'h77);
    check(get_slot(2) == mdl[2], "R8 aborted byte discarded", int'(get_slot(2)), int'(mdl[2]));

    // Soft reset inside a transfer: R7
    set_ptr(8'h1F, 8'h08);
    send_byte(8'h01, ack);
    check(ack, "R7 reset byte acknowledged", int'(ack), 1);
    send_byte(8'h5A, ack);
    check(ack, "R7 transfer continues after reset", int'(ack), 1);
    bus_stop();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      mdl[i] = is_mapped(i) ? dflt(i) : 8'h00;
      if (is_mapped(i))
        check(get_slot(i) == dflt(i), "R7 register reloaded", int'(get_slot(i)), int'(dflt(i)));
    end
    set_ptr(8'h19, 8'h08);
    bus_stop();
    read_run(25, 1, "R7 R6 identifier register after reload");
    bus_stop();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule